// File: doc/BRIEF.md
# Two-Wire Indexed Control Register Slave

This block is a slave on a two-wire management bus (SMBus style). It holds a nine-byte control register file for a differential clock fan-out device. A host reaches the file through two indexed block transfers. To write, the host addresses the slave, gives a starting offset and a byte count, and then streams that many data bytes. To read, the host writes an offset, issues a repeated start, and addresses the slave for reading. The slave answers with the contents of the byte-count register and then streams register bytes from the offset until the host declines a byte or stops.

The bus lines reach the block as raw levels and are oversampled on the system clock. The slave answers only through a pull-low enable for the data line. Three strap inputs pick one of eight bus addresses. Those straps, plus a bandwidth strap and a frequency-range strap, are captured while reset is held. The register contents drive the output-enable vector, the PLL bandwidth and bypass selections, the two group-ratio selects and an M:N gear ratio.

Top module: `smbx_ctl_slave`

## Requirements
- R1: The 7-bit slave address is 68h plus the latched strap value, so the 8-bit write address is D0h + 2*strap. Any other address byte is not acknowledged, and the slave stays silent until the next start.
- R2: A write transfer is: address (write), offset, count N, then N data bytes. Every byte is acknowledged, and the data bytes land in consecutive registers from the offset. Register 1 drives out_en[7:0]. Register 2 bits 5:0 drive out_en[13:8], bit 7 drives bw_low and bit 6 drives pll_on. Register 8 bits 4:0 drive out_en[18:14]. Register 0 bits 7:6 drive grp_sel.
- R3: A write count of zero is not acknowledged, and no register changes.
- R4: A data byte beyond the announced count is not acknowledged and is not written.
- R5: A read is: address (write), offset, repeated start, then address + 1. The slave first sends register 7 (byte count, reset value 09h) and then sends register bytes from the offset.
- R6: The register pointer increments after each data byte and wraps from 8 to 0.
- R7: Writes to read-only or reserved bits have no effect. Register 5 reads 05h and register 6 reads the DEVICE_ID parameter (default 91h). Register 0 bit 5 reads 0.
- R8: Register 3 reads {pin_oe_n[5:0], latched strap_bw_n, latched strap_addr[2]}. Register 4 reads pin_oe_n[13:6] live. Register 8 bit 7 and register 0 bit 4 read the frequency strap latched at reset. Later changes to the straps do not alter these bits or the address.
- R9: Register 0 bits 3:0 select the gear ratio {gear_m, gear_n}. For example, code 9 gives 1:1, code 15 gives 1:2, and code 7 gives 4:3 with the frequency strap at 0 and 5:4 with it at 1.
- R10: After reset, out_en is all ones, grp_sel=3, bw_low=1, pll_on=1, the gear code is 9 and sda_pull_low=0.
- R11: An offset of 9 or above is not acknowledged.
- R12: When the host declines a byte or stops, the slave releases the data line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low reset; the straps are captured while it is low |
| scl_in | input | 1 | Bus clock level |
| sda_in | input | 1 | Bus data level (wired line) |
| sda_pull_low | output | 1 | Pulls the data line low when 1 |
| strap_addr | input | 3 | Address strap |
| strap_bw_n | input | 1 | Bandwidth strap, read back only |
| strap_fsel | input | 1 | Frequency-range strap, used in the gear choice |
| pin_oe_n | input | 14 | Enable pin levels, read back only |
| out_en | output | 19 | Per-output enable bits |
| grp_sel | output | 2 | Group ratio selects |
| bw_low | output | 1 | PLL low-bandwidth select |
| pll_on | output | 1 | 1 = PLL used, 0 = bypass |
| gear_m | output | 4 | Gear ratio M |
| gear_n | output | 3 | Gear ratio N |

## Verification
A wrong pointer or byte role inside the slave shows up at the ports on the very next byte. An acknowledge appears where a not-acknowledge is expected, or a read byte comes from the wrong register, within nine bus clocks of the fault. A corrupted write strobe or mask appears in out_en, grp_sel or the gear outputs one system clock after the bus clock edge that ends the data byte. For that reason the bench rereads registers over the bus and inspects the control outputs after every transfer. A data line left pulled low after a host refusal or a stop is visible on sda_pull_low within a few system clocks.

// File: rtl/smbx_pkg.sv
package smbx_pkg;

  localparam int NUM_OUTS = 19;
  localparam int PIN_W    = 14;
  localparam logic [6:0] ADDR_BASE7 = 7'h68;
  localparam logic [7:0] VENDOR_REV = 8'h05;

  typedef enum logic [2:0] {
    L_IDLE, L_RX, L_RACK, L_TX, L_TACK, L_WAIT
  } link_state_e;

  typedef enum logic [1:0] {
    RL_ADDR, RL_OFFS, RL_CNT, RL_DATA
  } byte_role_e;

  function automatic logic [6:0] slave_addr7(input logic [2:0] sa);
    return ADDR_BASE7 + {4'b0000, sa};
  endfunction

  // returns {M[3:0], N[2:0]}
  function automatic logic [6:0] gear_ratio(input logic fs, input logic [3:0] code);
    logic [3:0] m;
    logic [2:0] n;
    unique case (code)
      4'd0:  begin m = 4'd3;  n = 3'd1; end
      4'd1:  begin m = 4'd5;  n = 3'd2; end
      4'd2:  begin m = 4'd12; n = 3'd5; end
      4'd3:  begin m = 4'd2;  n = 3'd1; end
      4'd4:  begin m = 4'd5;  n = 3'd3; end
      4'd5:  begin m = 4'd8;  n = 3'd5; end
      4'd6:  begin m = 4'd3;  n = 3'd2; end
      4'd7:  begin m = fs ? 4'd5 : 4'd4; n = fs ? 3'd4 : 3'd3; end
      4'd8:  begin m = 4'd6;  n = 3'd5; end
      4'd9:  begin m = 4'd1;  n = 3'd1; end
      4'd10: begin m = 4'd5;  n = 3'd6; end
      4'd11: begin m = 4'd4;  n = 3'd5; end
      4'd12: begin m = 4'd3;  n = 3'd4; end
      4'd13: begin m = 4'd2;  n = 3'd3; end
      4'd14: begin m = 4'd3;  n = 3'd5; end
      default: begin m = 4'd1; n = 3'd2; end
    endcase
    return {m, n};
  endfunction

  function automatic logic [7:0] wr_mask(input int idx);
    case (idx)
      0:       return 8'hCF;
      1, 2, 7: return 8'hFF;
      8:       return 8'h1F;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] rst_val(input int idx, input int nregs);
    case (idx)
      0:       return 8'hC9;
      1, 2:    return 8'hFF;
      7:       return 8'(nregs);
      8:       return 8'h1F;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/smbx_line_sync.sv
module smbx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_s, scl_q, sda_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_sh[g] <= 1'b1;
          sda_sh[g] <= 1'b1;
        end else if (g == 0) begin
          scl_sh[g] <= scl_in;
          sda_sh[g] <= sda_in;
        end else begin
          scl_sh[g] <= scl_sh[(g == 0) ? 0 : g-1];
          sda_sh[g] <= sda_sh[(g == 0) ? 0 : g-1];
        end
      end
    end
  endgenerate

  assign scl_s = scl_sh[STAGES-1];
  assign sda_s = sda_sh[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/smbx_link.sv
module smbx_link
  import smbx_pkg::*;
#(
  parameter int NUM_REGS = 9,
  localparam int PTR_W = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sda_s,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_det,
  input  logic             stop_det,
  input  logic [6:0]       dev_addr7,
  input  logic [7:0]       rd_data,
  input  logic [7:0]       cnt_byte,
  output logic [PTR_W-1:0] cur_ptr,
  output logic             wr_stb,
  output logic [7:0]       wr_data,
  output logic             sda_pull_low,
  output logic             quiet,
  output logic             ack_slot,
  output logic             tx_slot
);
  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(NUM_REGS - 1);

  link_state_e state;
  byte_role_e  role;
  logic [3:0]  bitcnt;
  logic [7:0]  shreg, txreg, remain;
  logic        is_read, mack, drive, byte_ack, byte_end;
  logic [PTR_W-1:0] ptr, ptr_next;

  assign ptr_next = (ptr == LAST_IDX) ? '0 : ptr + PTR_W'(1);
  assign byte_end = (state == L_RX) && scl_fall && (bitcnt == 4'd8);

  always_comb begin
    unique case (role)
      RL_ADDR: byte_ack = (shreg[7:1] == dev_addr7);
      RL_OFFS: byte_ack = (shreg < 8'(NUM_REGS));
      RL_CNT:  byte_ack = (shreg != 8'd0);
      default: byte_ack = (remain != 8'd0);
    endcase
  end

  assign wr_stb  = byte_end && (role == RL_DATA) && (remain != 8'd0)
                   && !start_det && !stop_det;
  assign wr_data = shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= L_IDLE;
      role    <= RL_ADDR;
      bitcnt  <= '0;
      shreg   <= '0;
      txreg   <= '0;
      remain  <= '0;
      ptr     <= '0;
      is_read <= 1'b0;
      mack    <= 1'b0;
      drive   <= 1'b0;
    end else if (start_det) begin
      state  <= L_RX;
      role   <= RL_ADDR;
      bitcnt <= '0;
      drive  <= 1'b0;
    end else if (stop_det) begin
      state <= L_IDLE;
      drive <= 1'b0;
    end else begin
      unique case (state)
        L_RX: begin
          if (scl_rise && bitcnt != 4'd8) begin
            shreg  <= {shreg[6:0], sda_s};
            bitcnt <= bitcnt + 4'd1;
          end
          if (byte_end) begin
            if (byte_ack) begin
              drive <= 1'b1;
              state <= L_RACK;
              unique case (role)
                RL_ADDR: is_read <= shreg[0];
                RL_OFFS: ptr <= shreg[PTR_W-1:0];
                RL_CNT:  remain <= shreg;
                default: begin
                  ptr    <= ptr_next;
                  remain <= remain - 8'd1;
                end
              endcase
            end else begin
              state <= L_WAIT;
            end
          end
        end
        L_RACK: begin
          if (scl_fall) begin
            bitcnt <= '0;
            if (role == RL_ADDR && is_read) begin
              txreg <= cnt_byte;
              drive <= ~cnt_byte[7];
              state <= L_TX;
            end else begin
              drive <= 1'b0;
              state <= L_RX;
              unique case (role)
                RL_ADDR: role <= RL_OFFS;
                RL_OFFS: role <= RL_CNT;
                default: role <= RL_DATA;
              endcase
            end
          end
        end
        L_TX: begin
          if (scl_rise) bitcnt <= bitcnt + 4'd1;
          if (scl_fall) begin
            if (bitcnt == 4'd8) begin
              drive <= 1'b0;
              state <= L_TACK;
            end else begin
              txreg <= {txreg[6:0], 1'b0};
              drive <= ~txreg[6];
            end
          end
        end
        L_TACK: begin
          if (scl_rise) mack <= ~sda_s;
          if (scl_fall) begin
            if (mack) begin
              txreg  <= rd_data;
              drive  <= ~rd_data[7];
              ptr    <= ptr_next;
              bitcnt <= '0;
              state  <= L_TX;
            end else begin
              state <= L_WAIT;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign cur_ptr      = ptr;
  assign sda_pull_low = drive;
  assign quiet        = (state == L_IDLE) || (state == L_WAIT);
  assign ack_slot     = (state == L_RACK);
  assign tx_slot      = (state == L_TX);
endmodule

// File: rtl/smbx_regs.sv
module smbx_regs
  import smbx_pkg::*;
#(
  parameter int NUM_REGS = 9,
  parameter logic [7:0] DEVICE_ID = 8'h91,
  localparam int PTR_W = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_stb,
  input  logic [PTR_W-1:0] wr_idx,
  input  logic [7:0]       wr_data,
  input  logic [PTR_W-1:0] rd_idx,
  input  logic [PIN_W-1:0] pin_oe_n,
  input  logic             fs_lat,
  input  logic             bw_lat,
  input  logic             a2_lat,
  output logic [7:0]       rd_data,
  output logic [7:0]       cnt_byte,
  output logic [NUM_OUTS-1:0] out_en,
  output logic [1:0]       grp_sel,
  output logic             bw_low,
  output logic             pll_on,
  output logic [3:0]       gear_m,
  output logic [2:0]       gear_n
);
  logic [7:0] store [NUM_REGS];
  logic [7:0] ro_bits;

  generate
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          store[g] <= rst_val(g, NUM_REGS) & wr_mask(g);
        else if (wr_stb && wr_idx == PTR_W'(g))
          store[g] <= wr_data & wr_mask(g);
      end
    end
  endgenerate

  always_comb begin
    unique case (rd_idx)
      PTR_W'(0): ro_bits = {3'b000, fs_lat, 4'b0000};
      PTR_W'(3): ro_bits = {pin_oe_n[5:0], bw_lat, a2_lat};
      PTR_W'(4): ro_bits = pin_oe_n[13:6];
      PTR_W'(5): ro_bits = VENDOR_REV;
      PTR_W'(6): ro_bits = DEVICE_ID;
      PTR_W'(8): ro_bits = {fs_lat, 7'b0000000};
      default:   ro_bits = 8'h00;
    endcase
  end

  assign rd_data  = store[rd_idx] | ro_bits;
  assign cnt_byte = store[7];
  assign out_en   = {store[8][4:0], store[2][5:0], store[1]};
  assign grp_sel  = store[0][7:6];
  assign bw_low   = store[2][7];
  assign pll_on   = store[2][6];
  assign {gear_m, gear_n} = gear_ratio(fs_lat, store[0][3:0]);
endmodule

// File: rtl/smbx_ctl_slave.sv
module smbx_ctl_slave
  import smbx_pkg::*;
#(
  parameter int NUM_REGS = 9,
  parameter int SYNC_STAGES = 2,
  parameter logic [7:0] DEVICE_ID = 8'h91
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                scl_in,
  input  logic                sda_in,
  output logic                sda_pull_low,
  input  logic [2:0]          strap_addr,
  input  logic                strap_bw_n,
  input  logic                strap_fsel,
  input  logic [PIN_W-1:0]    pin_oe_n,
  output logic [NUM_OUTS-1:0] out_en,
  output logic [1:0]          grp_sel,
  output logic                bw_low,
  output logic                pll_on,
  output logic [3:0]          gear_m,
  output logic [2:0]          gear_n
);
  localparam int PTR_W = $clog2(NUM_REGS);

  logic [2:0] addr_lat;
  logic       bw_lat, fs_lat;
  logic       sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic       wr_stb, link_quiet, link_ack_slot, link_tx_slot;
  logic [7:0] wr_data, rd_data, cnt_byte;
  logic [PTR_W-1:0] cur_ptr, wr_idx;

  // straps follow the pins while reset is held, then freeze
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_lat <= strap_addr;
      bw_lat   <= strap_bw_n;
      fs_lat   <= strap_fsel;
    end
  end

  smbx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  smbx_link #(.NUM_REGS(NUM_REGS)) u_link (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .dev_addr7(slave_addr7(addr_lat)), .rd_data(rd_data),
    .cnt_byte(cnt_byte), .cur_ptr(cur_ptr), .wr_stb(wr_stb),
    .wr_data(wr_data), .sda_pull_low(sda_pull_low), .quiet(link_quiet),
    .ack_slot(link_ack_slot), .tx_slot(link_tx_slot)
  );

  assign wr_idx = cur_ptr;

  smbx_regs #(.NUM_REGS(NUM_REGS), .DEVICE_ID(DEVICE_ID)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_idx(cur_ptr), .pin_oe_n(pin_oe_n),
    .fs_lat(fs_lat), .bw_lat(bw_lat), .a2_lat(addr_lat[2]),
    .rd_data(rd_data), .cnt_byte(cnt_byte), .out_en(out_en),
    .grp_sel(grp_sel), .bw_low(bw_low), .pll_on(pll_on),
    .gear_m(gear_m), .gear_n(gear_n)
  );
endmodule

// File: rtl/smbx_ctl_slave_chk.sv
module smbx_ctl_slave_chk #(
  parameter int NUM_REGS = 9,
  localparam int PTR_W = $clog2(NUM_REGS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sda_pull_low,
  input logic             link_quiet,
  input logic             link_ack_slot,
  input logic             link_tx_slot,
  input logic             stop_det,
  input logic             wr_stb,
  input logic [PTR_W-1:0] wr_idx,
  input logic [PTR_W-1:0] cur_ptr,
  input logic [18:0]      out_en,
  input logic [3:0]       gear_m,
  input logic [2:0]       gear_n
);
  a_r1_silent_when_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    link_quiet |-> !sda_pull_low);

  a_r5_drive_only_in_slots: assert property (@(posedge clk) disable iff (!rst_n)
    sda_pull_low |-> (link_ack_slot || link_tx_slot));

  a_r12_release_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_pull_low);

  a_r2_write_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> (wr_idx < PTR_W'(NUM_REGS)));

  a_r6_pointer_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && wr_idx == PTR_W'(NUM_REGS - 1)) |=> (cur_ptr == '0));

  a_r7_enables_move_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> $stable(out_en));

  a_r9_ratio_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    (gear_m != 4'd0) && (gear_n != 3'd0));
endmodule

bind smbx_ctl_slave smbx_ctl_slave_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk(clk), .rst_n(rst_n), .sda_pull_low(sda_pull_low),
  .link_quiet(link_quiet), .link_ack_slot(link_ack_slot),
  .link_tx_slot(link_tx_slot), .stop_det(stop_det), .wr_stb(wr_stb),
  .wr_idx(wr_idx), .cur_ptr(cur_ptr), .out_en(out_en),
  .gear_m(gear_m), .gear_n(gear_n)
);

// File: tb/test_smbx_ctl_slave.sv
module test_smbx_ctl_slave;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic sda_pull_low;
  logic [2:0] strap_addr = 3'b101;
  logic strap_bw_n = 1'b0, strap_fsel = 1'b1;
  logic [13:0] pin_oe_n = 14'h2A5C;
  logic [18:0] out_en;
  logic [1:0] grp_sel;
  logic bw_low, pll_on;
  logic [3:0] gear_m;
  logic [2:0] gear_n;
  wire sda_line = m_sda & ~sda_pull_low;

  always #(CLK_PERIOD/2) clk = ~clk;

  smbx_ctl_slave i_smbx_ctl_slave (
    .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_line),
    .sda_pull_low(sda_pull_low), .strap_addr(strap_addr),
    .strap_bw_n(strap_bw_n), .strap_fsel(strap_fsel), .pin_oe_n(pin_oe_n),
    .out_en(out_en), .grp_sel(grp_sel), .bw_low(bw_low), .pll_on(pll_on),
    .gear_m(gear_m), .gear_n(gear_n)
  );

  int checks = 0, failures = 0;
  bit finished = 0;
  int exp_q[$];
  string tag_q[$];
  int act_q[$];

  // scoreboard monitor
  initial forever begin
    @(negedge clk);
    while (exp_q.size() > 0 && act_q.size() > 0) begin
      automatic int e = exp_q.pop_front();
      automatic int a = act_q.pop_front();
      automatic string t = tag_q.pop_front();
      checks++;
      if (a != e) begin
        failures++;
        $display("FAIL %s actual=%0h expected=%0h", t, a, e);
      end
    end
  end

  task automatic expect_item(string t, int e);
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  task automatic chk(string t, int e, int a);
    expect_item(t, e);
    act_q.push_back(a);
  endtask

  task automatic qtr();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; qtr(); m_scl = 1'b1; qtr();
    m_sda = 1'b0; qtr(); m_scl = 1'b0; qtr();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; qtr(); m_scl = 1'b1; qtr(); m_sda = 1'b1; qtr();
  endtask

  task automatic tx(input logic [7:0] b, input int exp_ack, input string t);
    expect_item(t, exp_ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; qtr(); m_scl = 1'b1; qtr(); m_scl = 1'b0; qtr();
    end
    m_sda = 1'b1; qtr(); m_scl = 1'b1; qtr();
    act_q.push_back(sda_line == 1'b0 ? 1 : 0);
    m_scl = 1'b0; qtr();
  endtask

  task automatic rx(input int e, input logic nack, input string t);
    logic [7:0] b = '0;
    expect_item(t, e);
    m_sda = 1'b1;
    for (int i = 0; i < 8; i++) begin
      qtr(); m_scl = 1'b1; qtr(); b = {b[6:0], sda_line}; m_scl = 1'b0;
    end
    qtr(); m_sda = nack; qtr(); m_scl = 1'b1; qtr(); m_scl = 1'b0; qtr();
    m_sda = 1'b1;
    act_q.push_back(int'(b));
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    do_reset();
    // reset state
    chk("R10 out_en", 32'h7FFFF, int'(out_en));
    chk("R10 grp_sel", 3, int'(grp_sel));
    chk("R10 bw_low", 1, int'(bw_low));
    chk("R10 pll_on", 1, int'(pll_on));
    chk("R10 sda idle", 0, int'(sda_pull_low));
    chk("R9 reset gear", 32'h11, int'({gear_m, 1'b0, gear_n}));

    // wrong address, then bytes ignored
    bus_start();
    tx(8'hD0, 0, "R1 wrong addr nack");
    tx(8'h01, 0, "R1 ignored after bad addr");
    bus_stop();
    chk("R1 no change", 32'h7FFFF, int'(out_en));

    // block write two bytes at offset 1
    bus_start();
    tx(8'hDA, 1, "R1 addr ack");
    tx(8'h01, 1, "R2 offset ack");
    tx(8'h02, 1, "R2 count ack");
    tx(8'h0F, 1, "R2 data0 ack");
    tx(8'hA5, 1, "R2 data1 ack");
    bus_stop();
    chk("R2 out_en low", 32'h0F, int'(out_en[7:0]));
    chk("R2 out_en mid", 32'h25, int'(out_en[13:8]));
    chk("R2 bw_low", 1, int'(bw_low));
    chk("R2 pll_on", 0, int'(pll_on));

    // beyond count: last register, wrap target must stay untouched
    bus_start();
    tx(8'hDA, 1, "R4 addr");
    tx(8'h08, 1, "R4 offset");
    tx(8'h01, 1, "R4 count");
    tx(8'h03, 1, "R4 data");
    tx(8'hFF, 0, "R4 extra byte nack");
    bus_stop();
    chk("R4 out_en high", 3, int'(out_en[18:14]));
    chk("R4 gear untouched", 32'h11, int'({gear_m, 1'b0, gear_n}));

    // zero count
    bus_start();
    tx(8'hDA, 1, "R3 addr");
    tx(8'h01, 1, "R3 offset");
    tx(8'h00, 0, "R3 zero count nack");
    tx(8'h55, 0, "R3 data ignored");
    bus_stop();
    chk("R3 no write", 32'h0F, int'(out_en[7:0]));

    // out of range offset
    bus_start();
    tx(8'hDA, 1, "R11 addr");
    tx(8'h09, 0, "R11 offset nack");
    bus_stop();

    // indexed read from 7 wrapping to 0
    bus_start();
    tx(8'hDA, 1, "R5 addr");
    tx(8'h07, 1, "R5 offset");
    bus_start();
    tx(8'hDB, 1, "R5 read addr");
    rx(9, 1'b0, "R5 count byte");
    rx(9, 1'b0, "R5 reg7");
    rx(8'h83, 1'b0, "R8 reg8 fs latched");
    rx(8'hD9, 1'b1, "R6 wrap reg0");
    chk("R12 released after nack", 0, int'(sda_pull_low));
    bus_stop();

    // read-only bytes ignore writes
    bus_start();
    tx(8'hDA, 1, "R7 addr");
    tx(8'h03, 1, "R7 offset");
    tx(8'h03, 1, "R7 count");
    tx(8'hFF, 1, "R7 ro3");
    tx(8'hFF, 1, "R7 ro4");
    tx(8'hFF, 1, "R7 ro5");
    bus_stop();
    bus_start();
    tx(8'hDA, 1, "R7 addr");
    tx(8'h03, 1, "R7 offset");
    bus_start();
    tx(8'hDB, 1, "R7 read addr");
    rx(9, 1'b0, "R7 count");
    rx(8'h71, 1'b0, "R8 reg3 readback");
    rx(8'hA9, 1'b0, "R8 reg4 readback");
    rx(8'h05, 1'b0, "R7 vendor rev");
    rx(8'h91, 1'b1, "R7 device id");
    bus_stop();

    // gear code 7 with fs=1, reserved bits written
    bus_start();
    tx(8'hDA, 1, "R9 addr");
    tx(8'h00, 1, "R9 offset");
    tx(8'h01, 1, "R9 count");
    tx(8'h27, 1, "R9 data");
    bus_stop();
    chk("R9 gear 5:4", 32'h54, int'({gear_m, 1'b0, gear_n}));
    chk("R2 grp_sel", 0, int'(grp_sel));
    bus_start();
    tx(8'hDA, 1, "R7 addr");
    tx(8'h00, 1, "R7 offset");
    bus_start();
    tx(8'hDB, 1, "R7 read addr");
    rx(9, 1'b0, "R7 count");
    rx(8'h17, 1'b1, "R7 reg0 reserved bits");
    bus_stop();

    // straps changed after reset
    pin_oe_n = 14'h0000;
    strap_bw_n = 1'b1;
    strap_addr = 3'b000;
    bus_start();
    tx(8'hD0, 0, "R8 live strap not used");
    bus_stop();
    bus_start();
    tx(8'hDA, 1, "R8 latched addr");
    tx(8'h03, 1, "R8 offset");
    bus_start();
    tx(8'hDB, 1, "R8 read addr");
    rx(9, 1'b0, "R8 count");
    rx(8'h01, 1'b0, "R8 reg3 live pins");
    rx(8'h00, 1'b1, "R8 reg4 live pins");
    bus_stop();

    // new reset, fs=0, address strap 010
    strap_fsel = 1'b0;
    strap_addr = 3'b010;
    do_reset();
    chk("R10 out_en after reset", 32'h7FFFF, int'(out_en));
    bus_start();
    tx(8'hD4, 1, "R1 addr strap 2");
    tx(8'h00, 1, "R9 offset");
    tx(8'h01, 1, "R9 count");
    tx(8'h07, 1, "R9 data");
    bus_stop();
    chk("R9 gear 4:3", 32'h43, int'({gear_m, 1'b0, gear_n}));
    bus_start();
    tx(8'hD4, 1, "R9 addr");
    tx(8'h00, 1, "R9 offset");
    tx(8'h01, 1, "R9 count");
    tx(8'h0F, 1, "R9 data");
    bus_stop();
    chk("R9 gear 1:2", 32'h12, int'({gear_m, 1'b0, gear_n}));

    repeat (20) @(negedge clk);
    if (exp_q.size() != 0 || act_q.size() != 0) begin
      failures++;
      $display("FAIL scoreboard leftover actual=%0d expected=%0d",
               act_q.size(), exp_q.size());
    end
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule